// File: doc/BRIEF.md
# Sampled Occupancy Duration Alarm

This block turns a one-bit occupancy sensor into a latched alarm. It ignores the sensor level except on cycles that carry a slow timing strobe, nominally once per second. On each strobe it adds the sample to a run of consecutive "occupied" readings. A single "unoccupied" reading at a strobe ends the run.

When the run reaches a parameterised threshold (default 4), a registered alarm output goes high. The alarm then stays high whatever the sensor does, until the synchronous reset clears it. Reset is expected to be applied at power-up. Producing the strobe, synchronising the sensor and driving the sounder belong to other logic.

Two implementations can be chosen by parameter. One is a saturating run counter. The other is a history register that holds the previous threshold-minus-one strobe samples and is ANDed with the current sample. Both give the same behaviour at the ports.

Top module: `dwell_alarm`

## Requirements
- R1: One cycle after any clock edge where `rst` is high, `alarm` is 0, and the run is empty. After that, `THRESH` further occupied strobes are needed before `alarm` rises.
- R2: On cycles where `tick` is 0, the value of `sensor` has no effect on the run or on `alarm`.
- R3: A strobe (`tick`=1) with `sensor`=1 (occupied) extends the run by one. `alarm` goes to 1 on the clock edge that samples the `THRESH`-th consecutive occupied strobe, and never before it.
- R4: A strobe with `sensor`=0 (unoccupied) empties the run. After that, a full `THRESH` consecutive occupied strobes are needed again.
- R5: Once `alarm` is 1, it stays 1 on every later cycle, whatever the values of `tick` and `sensor`, until `rst` is applied.
- R6: When `rst` and an occupied strobe arrive in the same cycle, reset wins. The strobe is not counted, and `alarm` reads 0 on the next cycle.
- R7: The run count saturates at `THRESH` and does not wrap. An occupied run of any length leaves `alarm` at 1.
- R8: The history-register variant (`IMPL`=`DWELL_SHIFT`) and the counter variant (`IMPL`=`DWELL_COUNT`) produce identical `alarm` waveforms for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears run and alarm |
| tick | input | 1 | Single-cycle sampling strobe, nominally once per second |
| sensor | input | 1 | Occupancy level, 1 = occupied; used only when `tick` is 1 |
| alarm | output | 1 | Registered, latched alarm output |

## Verification
The assertions check several properties on every cycle. The run count never exceeds the threshold. The count and the history stay frozen when there is no strobe. An unoccupied strobe empties the count. Reset forces the alarm low on the next cycle. A set alarm holds. The alarm can rise only right after an occupied strobe. The directed scenarios cover behaviour that depends on whole sequences: the exact strobe on which the alarm rises, a broken run that must restart from zero, reset colliding with a strobe, and runs far longer than the threshold. Running both implementations side by side shows that they agree.

// File: rtl/dwell_pkg.sv
package dwell_pkg;
   typedef enum logic [0:0] {
      DWELL_COUNT = 1'b0,
      DWELL_SHIFT = 1'b1
   } dwell_impl_e;

   function automatic int run_width(input int thresh);
      return $clog2(thresh + 1);
   endfunction
endpackage

// File: rtl/dwell_run_count.sv
module dwell_run_count #(
   parameter int THRESH = 4,
   localparam int CW = dwell_pkg::run_width(THRESH)
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic sensor,
   output logic hit
);
   localparam logic [CW-1:0] TOP  = CW'(THRESH);
   localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else if (tick) begin
         if (!sensor)
            run_q <= '0;
         else if (run_q != TOP)
            run_q <= run_q + 1'b1;
      end
   end

   assign hit = tick && sensor && (run_q >= LAST);

   assert_run_bound_R7 : assert property (@(posedge clk) disable iff (rst)
      run_q <= TOP);

   assert_idle_frozen_R2 : assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(run_q));

   assert_vacant_clears_R4 : assert property (@(posedge clk) disable iff (rst)
      (tick && !sensor) |=> (run_q == '0));

   assert_occupied_step_R3 : assert property (@(posedge clk) disable iff (rst)
      (tick && sensor && run_q != TOP) |=> (run_q == $past(run_q) + 1'b1));
endmodule

// File: rtl/dwell_history.sv
module dwell_history #(
   parameter int THRESH = 4,
   localparam int HW = THRESH - 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic sensor,
   output logic hit
);
   logic [HW-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst)
         hist_q <= '0;
      else if (tick)
         hist_q <= (hist_q << 1) | HW'(sensor);
   end

   assign hit = tick && sensor && (&hist_q);

   assert_hist_frozen_R2 : assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(hist_q));

   assert_hist_newest_R4 : assert property (@(posedge clk) disable iff (rst)
      tick |=> (hist_q[0] == $past(sensor)));
endmodule

// File: rtl/dwell_latch.sv
module dwell_latch (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   output logic alarm_o
);
   always_ff @(posedge clk) begin
      if (rst)
         alarm_o <= 1'b0;
      else if (set_i)
         alarm_o <= 1'b1;
   end

   assert_reset_quiet_R1 : assert property (@(posedge clk)
      rst |=> !alarm_o);

   assert_alarm_holds_R5 : assert property (@(posedge clk) disable iff (rst)
      alarm_o |=> alarm_o);
endmodule

// File: rtl/dwell_alarm.sv
module dwell_alarm #(
   parameter int THRESH = 4,
   parameter dwell_pkg::dwell_impl_e IMPL = dwell_pkg::DWELL_COUNT
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic sensor,
   output logic alarm
);
   logic hit;

   if (THRESH < 2) begin : g_bad_thresh
      $error("dwell_alarm: THRESH must be at least 2");
   end

   if (IMPL == dwell_pkg::DWELL_SHIFT) begin : g_shift
      dwell_history #(.THRESH(THRESH)) u_hist (
         .clk(clk), .rst(rst), .tick(tick), .sensor(sensor), .hit(hit)
      );
   end else begin : g_count
      dwell_run_count #(.THRESH(THRESH)) u_count (
         .clk(clk), .rst(rst), .tick(tick), .sensor(sensor), .hit(hit)
      );
   end

   dwell_latch u_latch (
      .clk(clk), .rst(rst), .set_i(hit), .alarm_o(alarm)
   );

   assert_rise_on_strobe_R3 : assert property (@(posedge clk) disable iff (rst)
      $rose(alarm) |-> ($past(tick) && $past(sensor)));
endmodule

// File: tb/sim_dwell_alarm.sv
module sim_dwell_alarm;
   localparam int CLK_PERIOD = 10;
   localparam int THRESH = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic sensor = 1'b0;
   logic alarm_c, alarm_s;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dwell_alarm #(.THRESH(THRESH), .IMPL(dwell_pkg::DWELL_COUNT)) u0 (
      .clk(clk), .rst(rst), .tick(tick), .sensor(sensor), .alarm(alarm_c)
   );
   dwell_alarm #(.THRESH(THRESH), .IMPL(dwell_pkg::DWELL_SHIFT)) u1 (
      .clk(clk), .rst(rst), .tick(tick), .sensor(sensor), .alarm(alarm_s)
   );

   task automatic check(input string tag, input logic exp);
      total++;
      if (alarm_c !== exp) begin
         bad++;
         $display("FAIL %s counter alarm actual=%b expected=%b", tag, alarm_c, exp);
      end
      total++;
      if (alarm_s !== exp) begin
         bad++;
         $display("FAIL %s R8 history alarm actual=%b expected=%b", tag, alarm_s, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; tick = 1'b0;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic strobe(input logic s);
      @(negedge clk); tick = 1'b1; sensor = s;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic idle(input int n, input logic s);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b0; sensor = s ^ i[0];
      end
   endtask

   task automatic t_reset_R1();
      do_reset();
      check("R1 reset state", 1'b0);
   endtask

   task automatic t_basic_R3();
      do_reset();
      for (int i = 1; i < THRESH; i++) begin
         strobe(1'b1);
         check("R3 before threshold", 1'b0);
      end
      strobe(1'b1);
      check("R3 at threshold", 1'b1);
   endtask

   task automatic t_latch_R5();
      strobe(1'b0);
      idle(7, 1'b0);
      strobe(1'b0);
      check("R5 held after vacant samples", 1'b1);
      do_reset();
      check("R1 reset clears alarm", 1'b0);
      for (int i = 1; i < THRESH; i++) strobe(1'b1);
      check("R1 run emptied by reset", 1'b0);
      strobe(1'b1);
      check("R1 full run after reset", 1'b1);
   endtask

   task automatic t_ignore_R2();
      do_reset();
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); sensor = 1'b1; tick = 1'b0;
         @(negedge clk);
         strobe(1'b0);
      end
      idle(20, 1'b1);
      check("R2 sensor high off-strobe ignored", 1'b0);
      for (int i = 1; i < THRESH; i++) begin
         strobe(1'b1);
         idle(5, 1'b0);
      end
      check("R2 sensor low off-strobe ignored", 1'b0);
      strobe(1'b1);
      check("R2 run spans idle gaps", 1'b1);
   endtask

   task automatic t_break_R4();
      do_reset();
      for (int i = 1; i < THRESH; i++) strobe(1'b1);
      strobe(1'b0);
      for (int i = 1; i < THRESH; i++) strobe(1'b1);
      check("R4 broken run restarts", 1'b0);
      strobe(1'b1);
      check("R4 fresh full run", 1'b1);
   endtask

   task automatic t_rstprio_R6();
      do_reset();
      for (int i = 1; i < THRESH; i++) strobe(1'b1);
      @(negedge clk); rst = 1'b1; tick = 1'b1; sensor = 1'b1;
      @(negedge clk); rst = 1'b0; tick = 1'b0;
      check("R6 reset beats strobe", 1'b0);
      for (int i = 1; i < THRESH; i++) strobe(1'b1);
      check("R6 strobe not counted", 1'b0);
      strobe(1'b1);
      check("R6 full run afterwards", 1'b1);
   endtask

   task automatic t_long_R7();
      do_reset();
      for (int i = 1; i <= 2*THRESH + 9; i++) begin
         strobe(1'b1);
         if (i == THRESH - 1) check("R7 one short", 1'b0);
      end
      check("R7 long run stays alarmed", 1'b1);
      strobe(1'b0);
      check("R7 held after long run", 1'b1);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset_R1();
      t_basic_R3();
      t_latch_R5();
      t_ignore_R2();
      t_break_R4();
      t_rstprio_R6();
      t_long_R7();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule